// File: doc/BRIEF.md
# H-Bridge Mode Decoder with Fixed-Off-Time Chopping

This block drives the four gate enables (high side and low side of each leg) of one H-bridge. It works from a power-enable input and two direction inputs, which select between standby, outputs off, forward, reverse and brake. Any change of the requested mode passes through a dead interval in which every switch is off. Only then is the new leg pattern applied, so a leg is never switched straight from one side to the other on a mode change.

While the bridge drives forward or reverse, a digital over-current comparator input is watched, but only after a blanking window that follows every entry into drive. A trip after blanking puts the bridge into slow decay with both low sides on and both high sides off. Decay lasts a length taken from a shared timer-setting input, after which drive resumes with a fresh blanking window. A flag output is high for the whole decay. Dead time and blanking length are parameters in clock cycles.

Top module: `hbridge_chop_ctl`

## Requirements
- R1: While pwrEn is low, all four gate enables are low one clock edge later and stay low, whatever dirA, dirB and ocTrip do.
- R2: With pwrEn high, dirA=1 and dirB=0 select forward (hiA and loB on, loA and hiB off). dirA=0 and dirB=1 select reverse (loA and hiB on, hiA and loB off).
- R3: With pwrEn high, dirA=1 and dirB=1 select brake (loA and loB on, both high sides off). dirA=0 and dirB=0 turn all four gates off.
- R4: When the requested mode differs from the applied one, all four gates are off from the next edge for DEAD_CYC cycles. The new pattern appears at the edge DEAD_CYC+1 after the change.
- R5: ocTrip has no effect during the BLANK_CYC cycles that follow each entry into forward or reverse drive, including the entry after each decay.
- R6: An ocTrip high at the first edge after blanking, or at any later edge in drive, starts slow decay at that edge: loA and loB on, hiA and hiB off. Decay lasts offTimeCfg+1 cycles, with offTimeCfg sampled when decay begins. Drive then resumes with a new blanking window.
- R7: limitActive is high in exactly the cycles of slow decay.
- R8: ocTrip has no effect in standby, outputs-off or brake: limitActive stays low and the gate pattern is unchanged.
- R9: hiA and loA are never on together, and hiB and loB are never on together.
- R10: A mode change during decay ends the decay at once: limitActive drops and the dead interval of R4 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrEn | input | 1 | High enables the bridge, low is standby |
| dirA | input | 1 | Direction input one |
| dirB | input | 1 | Direction input two |
| ocTrip | input | 1 | Over-current comparator, high when over limit |
| offTimeCfg | input | OFF_W | Shared timer setting; decay lasts this value plus one cycles |
| hiA | output | 1 | Leg A high-side enable |
| loA | output | 1 | Leg A low-side enable |
| hiB | output | 1 | Leg B high-side enable |
| loB | output | 1 | Leg B low-side enable |
| limitActive | output | 1 | High during slow decay |

## Verification
Every result is a function of registered state, so each one is due a whole number of edges after the stimulus. Standby and the start of the dead interval arrive one edge after the input change. A new drive pattern arrives at edge DEAD_CYC+1. The first decay arrives at edge DEAD_CYC+BLANK_CYC+1 when the trip is already high. Drive returns offTimeCfg+1 edges after decay starts. The bench drives inputs on the falling edge and counts rising edges to exactly those offsets. It samples on the falling edge and checks both the last cycle before each transition and the first cycle after it.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

  typedef enum logic [2:0] {
    MD_STBY  = 3'd0,
    MD_IDLE  = 3'd1,
    MD_FWD   = 3'd2,
    MD_REV   = 3'd3,
    MD_BRAKE = 3'd4
  } mode_e;

  typedef enum logic [2:0] {
    PH_HOLD  = 3'd0,
    PH_DEAD  = 3'd1,
    PH_BLANK = 3'd2,
    PH_RUN   = 3'd3,
    PH_DECAY = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    LD_DEAD  = 2'd0,
    LD_BLANK = 2'd1,
    LD_OFF   = 2'd2
  } loadSel_e;

  typedef enum logic [1:0] {
    GS_OFF   = 2'd0,
    GS_DRIVE = 2'd1,
    GS_DECAY = 2'd2
  } gateSel_e;

  typedef struct packed {
    logic     cntLoad;
    loadSel_e loadSel;
    gateSel_e gateSel;
    mode_e    mode;
  } strobe_t;

  function automatic int cntWidth(int deadCyc, int blankCyc, int offW);
    int w;
    w = offW;
    if ($clog2(deadCyc) > w) w = $clog2(deadCyc);
    if ($clog2(blankCyc) > w) w = $clog2(blankCyc);
    if (w < 1) w = 1;
    return w;
  endfunction

endpackage

// File: rtl/hbc_ctrl.sv
module hbc_ctrl
  import hbc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pwrEn,
  input  logic    dirA,
  input  logic    dirB,
  input  logic    ocTrip,
  input  logic    cntDone,
  output strobe_t strb
);

  mode_e  reqMode;
  mode_e  curMode, nxtMode;
  phase_e phase, nxtPhase;
  logic   nxtLoad;
  loadSel_e nxtSel;

  always_comb begin
    if (!pwrEn) reqMode = MD_STBY;
    else begin
      unique case ({dirA, dirB})
        2'b10:   reqMode = MD_FWD;
        2'b01:   reqMode = MD_REV;
        2'b11:   reqMode = MD_BRAKE;
        default: reqMode = MD_IDLE;
      endcase
    end
  end

  function automatic logic isDrive(mode_e m);
    return (m == MD_FWD) || (m == MD_REV);
  endfunction

  always_comb begin
    nxtPhase = phase;
    nxtMode  = curMode;
    nxtLoad  = 1'b0;
    nxtSel   = LD_DEAD;
    if (reqMode != curMode) begin
      nxtPhase = PH_DEAD;
      nxtMode  = reqMode;
      nxtLoad  = 1'b1;
      nxtSel   = LD_DEAD;
    end else begin
      unique case (phase)
        PH_DEAD: if (cntDone) begin
          if (isDrive(curMode)) begin
            nxtPhase = PH_BLANK;
            nxtLoad  = 1'b1;
            nxtSel   = LD_BLANK;
          end else begin
            nxtPhase = PH_HOLD;
          end
        end
        PH_BLANK: if (cntDone) begin
          if (ocTrip) begin
            nxtPhase = PH_DECAY;
            nxtLoad  = 1'b1;
            nxtSel   = LD_OFF;
          end else begin
            nxtPhase = PH_RUN;
          end
        end
        PH_RUN: if (ocTrip) begin
          nxtPhase = PH_DECAY;
          nxtLoad  = 1'b1;
          nxtSel   = LD_OFF;
        end
        PH_DECAY: if (cntDone) begin
          nxtPhase = PH_BLANK;
          nxtLoad  = 1'b1;
          nxtSel   = LD_BLANK;
        end
        default: nxtPhase = PH_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_HOLD;
      curMode <= MD_STBY;
    end else begin
      phase   <= nxtPhase;
      curMode <= nxtMode;
    end
  end

  always_comb begin
    strb.cntLoad = nxtLoad;
    strb.loadSel = nxtSel;
    strb.mode    = curMode;
    unique case (phase)
      PH_DEAD:  strb.gateSel = GS_OFF;
      PH_DECAY: strb.gateSel = GS_DECAY;
      default:  strb.gateSel = GS_DRIVE;
    endcase
  end

  // R4: a mode request that differs from the applied mode opens a dead interval
  p_dead_on_change_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqMode != curMode) |=> (phase == PH_DEAD));

  // R5: no decay can start while blanking is still counting
  p_blank_masks_trip_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_BLANK && !cntDone) |=> (phase != PH_DECAY));

  // R6: a trip seen in run with a steady request starts decay
  p_trip_starts_decay_r6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RUN && ocTrip && reqMode == curMode) |=> (phase == PH_DECAY));

  // R8: non-driving modes never enter decay
  p_no_decay_static_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_DECAY && !isDrive(reqMode)) |=> (phase != PH_DECAY));

endmodule

// File: rtl/hbc_datapath.sv
module hbc_datapath
  import hbc_pkg::*;
#(
  parameter int DEAD_CYC  = 20,
  parameter int BLANK_CYC = 400,
  parameter int OFF_W     = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [OFF_W-1:0] offTimeCfg,
  output logic             cntDone,
  output logic             hiA,
  output logic             loA,
  output logic             hiB,
  output logic             loB,
  output logic             limitActive
);

  localparam int CNT_W = cntWidth(DEAD_CYC, BLANK_CYC, OFF_W);
  localparam logic [CNT_W-1:0] DEAD_LD  = CNT_W'(DEAD_CYC - 1);
  localparam logic [CNT_W-1:0] BLANK_LD = CNT_W'(BLANK_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    unique case (strb.loadSel)
      LD_BLANK: loadVal = BLANK_LD;
      LD_OFF:   loadVal = CNT_W'(offTimeCfg);
      default:  loadVal = DEAD_LD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (strb.cntLoad)    cnt <= loadVal;
    else if (cnt != '0)       cnt <= cnt - 1'b1;
  end

  assign cntDone = (cnt == '0);

  always_comb begin
    hiA = 1'b0;
    loA = 1'b0;
    hiB = 1'b0;
    loB = 1'b0;
    unique case (strb.gateSel)
      GS_DECAY: begin
        loA = 1'b1;
        loB = 1'b1;
      end
      GS_DRIVE: begin
        unique case (strb.mode)
          MD_FWD:   begin hiA = 1'b1; loB = 1'b1; end
          MD_REV:   begin loA = 1'b1; hiB = 1'b1; end
          MD_BRAKE: begin loA = 1'b1; loB = 1'b1; end
          default:  ;
        endcase
      end
      default: ;
    endcase
  end

  assign limitActive = (strb.gateSel == GS_DECAY);

  // R9: neither leg conducts through both switches
  p_leg_a_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(hiA && loA));
  p_leg_b_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(hiB && loB));

  // R7: the limit flag only accompanies the slow-decay pattern
  p_flag_means_decay_r7: assert property (@(posedge clk) disable iff (!rstN)
    limitActive |-> (loA && loB && !hiA && !hiB));

endmodule

// File: rtl/hbridge_chop_ctl.sv
module hbridge_chop_ctl
  import hbc_pkg::*;
#(
  parameter int DEAD_CYC  = 20,
  parameter int BLANK_CYC = 400,
  parameter int OFF_W     = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pwrEn,
  input  logic             dirA,
  input  logic             dirB,
  input  logic             ocTrip,
  input  logic [OFF_W-1:0] offTimeCfg,
  output logic             hiA,
  output logic             loA,
  output logic             hiB,
  output logic             loB,
  output logic             limitActive
);

  strobe_t strb;
  logic    cntDone;

  hbc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pwrEn   (pwrEn),
    .dirA    (dirA),
    .dirB    (dirB),
    .ocTrip  (ocTrip),
    .cntDone (cntDone),
    .strb    (strb)
  );

  hbc_datapath #(
    .DEAD_CYC  (DEAD_CYC),
    .BLANK_CYC (BLANK_CYC),
    .OFF_W     (OFF_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .offTimeCfg  (offTimeCfg),
    .cntDone     (cntDone),
    .hiA         (hiA),
    .loA         (loA),
    .hiB         (hiB),
    .loB         (loB),
    .limitActive (limitActive)
  );

  // R1: standby forces every gate off one edge later
  p_standby_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    !pwrEn |=> !(hiA || loA || hiB || loB));

endmodule

// File: tb/hbridge_chop_ctl_tb.sv
module hbridge_chop_ctl_tb;

  localparam int D     = 5;
  localparam int B     = 12;
  localparam int OFF_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrEn = 1'b0, dirA = 1'b0, dirB = 1'b0, ocTrip = 1'b0;
  logic [OFF_W-1:0] offTimeCfg = '0;
  logic hiA, loA, hiB, loB, limitActive;

  int nChecks = 0;
  int nFails  = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  hbridge_chop_ctl #(.DEAD_CYC(D), .BLANK_CYC(B), .OFF_W(OFF_W)) u_dut (
    .clk(clk), .rstN(rstN), .pwrEn(pwrEn), .dirA(dirA), .dirB(dirB),
    .ocTrip(ocTrip), .offTimeCfg(offTimeCfg),
    .hiA(hiA), .loA(loA), .hiB(hiB), .loB(loB), .limitActive(limitActive)
  );

  localparam logic [4:0] G_OFF   = 5'b0000_0;
  localparam logic [4:0] G_FWD   = 5'b1001_0;
  localparam logic [4:0] G_REV   = 5'b0110_0;
  localparam logic [4:0] G_BRAKE = 5'b0101_0;
  localparam logic [4:0] G_DECAY = 5'b0101_1;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect5(string req, logic [4:0] exp);
    logic [4:0] act;
    act = {hiA, loA, hiB, loB, limitActive};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {hiA,loA,hiB,loB,limit} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic setMode(logic p, logic a, logic b);
    pwrEn = p; dirA = a; dirB = b;
  endtask

  task automatic goStandby();
    setMode(1'b0, 1'b0, 1'b0);
    ocTrip = 1'b0;
    tick(D + 2);
  endtask

  task automatic tReset();
    expect5("R1 reset", G_OFF);
  endtask

  task automatic tStandby();
    setMode(1'b0, 1'b1, 1'b1);
    ocTrip = 1'b1;
    tick(1);
    expect5("R1 standby brake inputs", G_OFF);
    setMode(1'b0, 1'b1, 1'b0);
    tick(D + B + 4);
    expect5("R1 standby forward inputs with trip", G_OFF);
    ocTrip = 1'b0;
  endtask

  task automatic tModes();
    goStandby();
    setMode(1'b1, 1'b1, 1'b0);
    tick(1);
    expect5("R4 dead start", G_OFF);
    tick(D - 1);
    expect5("R4 dead last cycle", G_OFF);
    tick(1);
    expect5("R2 forward", G_FWD);
    setMode(1'b1, 1'b0, 1'b1);
    tick(D);
    expect5("R4 dead fwd->rev", G_OFF);
    tick(1);
    expect5("R2 reverse", G_REV);
    setMode(1'b1, 1'b1, 1'b1);
    tick(D);
    expect5("R4 dead rev->brake", G_OFF);
    tick(1);
    expect5("R3 brake", G_BRAKE);
    setMode(1'b1, 1'b0, 1'b0);
    tick(D + 1);
    expect5("R3 outputs off", G_OFF);
    tick(B);
    expect5("R3 outputs off hold", G_OFF);
  endtask

  task automatic tChop();
    goStandby();
    offTimeCfg = 6'd3;
    ocTrip = 1'b1;
    setMode(1'b1, 1'b1, 1'b0);
    tick(D + B);
    expect5("R5 trip masked in blank", G_FWD);
    tick(1);
    expect5("R6 decay after blank", G_DECAY);
    offTimeCfg = 6'd20;
    tick(3);
    expect5("R7 decay last cycle", G_DECAY);
    tick(1);
    expect5("R6 drive resumes", G_FWD);
    tick(B - 1);
    expect5("R5 blank restarts after decay", G_FWD);
    tick(1);
    expect5("R6 second decay", G_DECAY);
    offTimeCfg = 6'd3;
    ocTrip = 1'b0;
    tick(21);
    expect5("R6 sampled off time end", G_FWD);
    tick(B + 3);
    expect5("R6 run without trip", G_FWD);
    ocTrip = 1'b1;
    tick(1);
    expect5("R6 trip in run", G_DECAY);
    ocTrip = 1'b0;
    setMode(1'b1, 1'b0, 1'b1);
    tick(1);
    expect5("R10 abort decay", G_OFF);
    tick(D);
    expect5("R10 new mode after dead", G_REV);
  endtask

  task automatic tOffZero();
    goStandby();
    offTimeCfg = '0;
    ocTrip = 1'b1;
    setMode(1'b1, 1'b0, 1'b1);
    tick(D + B + 1);
    expect5("R6 single-cycle decay", G_DECAY);
    tick(1);
    expect5("R6 single-cycle decay end", G_REV);
    ocTrip = 1'b0;
  endtask

  task automatic tIgnore();
    goStandby();
    offTimeCfg = 6'd4;
    ocTrip = 1'b1;
    setMode(1'b1, 1'b1, 1'b1);
    tick(D + B + 5);
    expect5("R8 trip ignored in brake", G_BRAKE);
    setMode(1'b1, 1'b0, 1'b0);
    tick(D + B + 5);
    expect5("R8 trip ignored in off", G_OFF);
    ocTrip = 1'b0;
  endtask

  task automatic tDrop();
    goStandby();
    setMode(1'b1, 1'b1, 1'b0);
    tick(D + B + 3);
    expect5("R2 forward before drop", G_FWD);
    pwrEn = 1'b0;
    tick(1);
    expect5("R1 power drop", G_OFF);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    tReset();
    tStandby();
    tModes();
    tChop();
    tOffZero();
    tIgnore();
    tDrop();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule